// File: doc/BRIEF.md
# Nested Trap Level State Stack

This block keeps the processor context that must survive a trap, one slot per nesting level. When a trap is accepted it stores the interrupted program counter, next program counter and trap type in the slot of the current level. It also packs the condition codes, address-space identifier, 12-bit processor-state word and window pointer into a single 40-bit word in that slot. It then forms a trap vector from the trap base register and moves to the next level.

Two return commands pop one level. The resume-after command continues at the saved next PC. The re-execute command goes back to the saved PC. Both put back the saved condition codes, address-space identifier, processor state and window pointer. Near the deepest level the processor state gets its reduced-state flag. A trap that arrives at the deepest level sends the block into a sticky error state.

The surrounding pipeline drives fetch from `new_pc`/`new_npc` and moves the register window from `st_win`. Neither fetch nor window movement happens here.

Top module: `trap_level_stack`

## Requirements
- R1: After a synchronous active-low reset, `trap_lvl` is 0, `err_state` is 0, and `new_pc`, `new_npc`, `st_pstate`, `top_state` and the trap base register are all zero.
- R2: An accepted trap stores its trap type, PC and next PC in the slot indexed by the level held before entry. The stored trap type then appears on `top_tt` while that slot is the innermost one.
- R3: The saved context word places the condition codes at bits [39:32], the address-space identifier at [31:24], the processor state at [19:8] and the window pointer at [7:0], with bits [23:20] zero. `top_state` shows the word of the innermost level, or zero at level 0.
- R4: After an accepted trap, `st_pstate` is 12'h015: bit 0 alternate globals, bit 2 privileged, bit 4 FP enable. `st_ccr`, `st_asi` and `st_win` take the values presented with the trap.
- R5: After an accepted trap, `new_pc` equals the trap base register with bits [14:0] replaced. Bit 14 is 1 when the level before entry was greater than 1. Bits [13:5] hold the trap type and bits [4:0] are zero. `new_npc` equals `new_pc`+4, and the trap base register keeps this vector.
- R6: An accepted trap at a level below MAX_LVL-1 raises the level by one with no reduced-state flag. At level MAX_LVL-1 the level still rises, to MAX_LVL, and `st_pstate` bit 5 (reduced state) is also set, giving 12'h035.
- R7: A trap requested at level MAX_LVL sets `err_state`. It changes neither the level nor the outputs. `err_state` stays set until reset, and while it is set every trap and return request is ignored.
- R8: A return with `ret_mode`=0 (resume-after) lowers the level by one. It loads `new_pc` with the saved next PC and `new_npc` with the saved next PC plus 4, and restores the four context fields from the saved word.
- R9: A return with `ret_mode`=1 (re-execute) lowers the level by one. It loads `new_pc` with the saved PC and `new_npc` with the saved next PC, and restores the four context fields.
- R10: A return requested at level 0 is ignored: level and all outputs are unchanged.
- R11: When a trap and a return are requested in the same cycle, the trap is taken and the return is dropped.
- R12: A write on `tbase_wr` loads the trap base register. The next trap vector uses bits [ADDR_W-1:15] of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbase_wr | input | 1 | Load the trap base register |
| tbase_wdata | input | ADDR_W | Value for the trap base register |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type code |
| cur_pc | input | ADDR_W | Interrupted PC |
| cur_npc | input | ADDR_W | Interrupted next PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor-state word |
| cur_win | input | 8 | Current window pointer |
| ret_req | input | 1 | Return from the innermost trap |
| ret_mode | input | 1 | 0 resume-after, 1 re-execute |
| new_pc | output | ADDR_W | PC to fetch from |
| new_npc | output | ADDR_W | Next PC to fetch from |
| st_ccr | output | 8 | Condition codes in effect |
| st_asi | output | 8 | Address-space identifier in effect |
| st_pstate | output | 12 | Processor-state word in effect |
| st_win | output | 8 | Window pointer in effect |
| top_state | output | 40 | Saved context word of the innermost level |
| top_tt | output | 9 | Saved trap type of the innermost level |
| trap_lvl | output | LW | Current nesting level |
| err_state | output | 1 | Sticky error state |

## Verification
A trap entry and a return can both be requested in the same clock cycle. This is the one point where the two paths compete for the level counter and the outputs. The bench raises both at level 1, where the return alone would be legal. It judges the result by checking that the level rises to 2 and that `new_pc` carries the freshly computed vector rather than a restored address. A later pair of returns then confirms that the stack contents were not disturbed by the dropped return.

// File: rtl/tls_pkg.sv
// Package: shared field layout for the trap level state stack.
// Assumes 8-bit condition codes, ASI and window pointer and a 12-bit
// processor-state word; the packed word layout is decoded by neighbours.
package tls_pkg;
    localparam int CCR_W = 8;
    localparam int ASI_W = 8;
    localparam int PST_W = 12;
    localparam int WIN_W = 8;
    localparam int TT_W  = 9;
    localparam int SW_W  = 40;

    localparam int VEC_LOW_W   = 15;
    localparam int VEC_TT_LSB  = 5;

    localparam logic [PST_W-1:0] PST_ENTRY    = 12'h015;
    localparam logic [PST_W-1:0] PST_RED_MASK = 12'h020;

    function automatic logic [SW_W-1:0] pack_state(
        input logic [CCR_W-1:0] ccr,
        input logic [ASI_W-1:0] asi,
        input logic [PST_W-1:0] pst,
        input logic [WIN_W-1:0] win
    );
        return {ccr, asi, 4'h0, pst, win};
    endfunction
endpackage

// File: rtl/tls_level_store.sv
// Module: per-level storage of saved PC, next PC, context word and trap type.
// Assumes wr_idx < DEPTH whenever wr_en is high; read is combinational.
module tls_level_store
    import tls_pkg::*;
#(
    parameter int DEPTH  = 5,
    parameter int ADDR_W = 32,
    localparam int IW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_npc,
    input  logic [SW_W-1:0]   wr_word,
    input  logic [TT_W-1:0]   wr_tt,
    input  logic [IW-1:0]     rd_idx,
    output logic [ADDR_W-1:0] rd_pc,
    output logic [ADDR_W-1:0] rd_npc,
    output logic [SW_W-1:0]   rd_word,
    output logic [TT_W-1:0]   rd_tt
);
    logic [ADDR_W-1:0] pc_mem  [DEPTH];
    logic [ADDR_W-1:0] npc_mem [DEPTH];
    logic [SW_W-1:0]   sw_mem  [DEPTH];
    logic [TT_W-1:0]   tt_mem  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
        // Capture one level's slot when a trap writes to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_mem[g]  <= '0;
                npc_mem[g] <= '0;
                sw_mem[g]  <= '0;
                tt_mem[g]  <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                pc_mem[g]  <= wr_pc;
                npc_mem[g] <= wr_npc;
                sw_mem[g]  <= wr_word;
                tt_mem[g]  <= wr_tt;
            end
        end
    end

    // Select the slot addressed by rd_idx.
    always_comb begin
        rd_pc   = '0;
        rd_npc  = '0;
        rd_word = '0;
        rd_tt   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_pc   = pc_mem[i];
                rd_npc  = npc_mem[i];
                rd_word = sw_mem[i];
                rd_tt   = tt_mem[i];
            end
        end
    end

    p_wr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IW'(DEPTH)));
endmodule

// File: rtl/tls_level_ctrl.sv
// Module: nesting level counter, request arbitration and sticky error state.
// Assumes a trap request wins over a return request in the same cycle.
module tls_level_ctrl #(
    parameter int MAX_LVL = 5,
    localparam int LW     = $clog2(MAX_LVL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_req,
    input  logic          ret_req,
    output logic [LW-1:0] lvl,
    output logic          err,
    output logic          take_trap,
    output logic          take_ret,
    output logic          go_red
);
    logic at_max;
    logic at_zero;

    // Decide which request is accepted this cycle.
    always_comb begin
        at_max    = (lvl == LW'(MAX_LVL));
        at_zero   = (lvl == '0);
        take_trap = trap_req && !err && !at_max;
        take_ret  = ret_req && !trap_req && !err && !at_zero;
        go_red    = take_trap && (lvl == LW'(MAX_LVL - 1));
    end

    // Track the level and latch the error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0;
            err <= 1'b0;
        end else if (trap_req && !err && at_max) begin
            err <= 1'b1;
        end else if (take_trap) begin
            lvl <= lvl + 1'b1;
        end else if (take_ret) begin
            lvl <= lvl - 1'b1;
        end
    end

    p_lvl_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LW'(MAX_LVL));
    p_trap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (lvl == $past(lvl) + 1'b1));
    p_ret_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> (lvl == $past(lvl) - 1'b1));
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(lvl)));
    p_both_trap_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ret_req) |-> !take_ret);
endmodule

// File: rtl/tls_vector_gen.sv
// Module: forms the trap vector from the trap base register.
// Assumes ADDR_W >= 16; bit 14 flags nesting deeper than level 1.
module tls_vector_gen
    import tls_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] tbr,
    input  logic              lvl_gt1,
    input  logic [TT_W-1:0]   tt,
    output logic [ADDR_W-1:0] vec
);
    // Replace the low 15 bits with nesting flag, type and zero offset.
    always_comb begin
        vec = {tbr[ADDR_W-1:VEC_LOW_W], lvl_gt1, tt, {VEC_TT_LSB{1'b0}}};
    end
endmodule

// File: rtl/trap_level_stack.sv
// Module: top of the nested trap state stack. Accepts trap entries and
// resume-after / re-execute returns and drives the resulting PC pair and
// context fields from registers. Assumes one request of each kind per cycle.
module trap_level_stack
    import tls_pkg::*;
#(
    parameter int  MAX_LVL = 5,
    parameter int  ADDR_W  = 32,
    localparam int LW      = $clog2(MAX_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbase_wr,
    input  logic [ADDR_W-1:0] tbase_wdata,
    input  logic              trap_req,
    input  logic [8:0]        trap_type,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_npc,
    input  logic [7:0]        cur_ccr,
    input  logic [7:0]        cur_asi,
    input  logic [11:0]       cur_pstate,
    input  logic [7:0]        cur_win,
    input  logic              ret_req,
    input  logic              ret_mode,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_npc,
    output logic [7:0]        st_ccr,
    output logic [7:0]        st_asi,
    output logic [11:0]       st_pstate,
    output logic [7:0]        st_win,
    output logic [39:0]       top_state,
    output logic [8:0]        top_tt,
    output logic [LW-1:0]     trap_lvl,
    output logic              err_state
);
    logic              take_trap, take_ret, go_red;
    logic [LW-1:0]     lvl;
    logic              err;
    logic [ADDR_W-1:0] tbr_q;
    logic [ADDR_W-1:0] vec;
    logic [LW-1:0]     rd_idx;
    logic [ADDR_W-1:0] rd_pc, rd_npc;
    logic [SW_W-1:0]   rd_word;
    logic [TT_W-1:0]   rd_tt;
    logic [SW_W-1:0]   wr_word;

    tls_level_ctrl #(.MAX_LVL(MAX_LVL)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .ret_req(ret_req),
        .lvl(lvl), .err(err), .take_trap(take_trap), .take_ret(take_ret),
        .go_red(go_red)
    );

    tls_vector_gen #(.ADDR_W(ADDR_W)) vec_i (
        .tbr(tbr_q), .lvl_gt1(lvl > LW'(1)), .tt(trap_type), .vec(vec)
    );

    // Innermost slot index; slot 0 is read at level 0 but masked below.
    always_comb begin
        rd_idx  = (lvl == '0) ? '0 : lvl - 1'b1;
        wr_word = pack_state(cur_ccr, cur_asi, cur_pstate, cur_win);
    end

    tls_level_store #(.DEPTH(MAX_LVL), .ADDR_W(ADDR_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(take_trap), .wr_idx(lvl),
        .wr_pc(cur_pc), .wr_npc(cur_npc), .wr_word(wr_word), .wr_tt(trap_type),
        .rd_idx(rd_idx), .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_word(rd_word),
        .rd_tt(rd_tt)
    );

    // Trap base register: explicit write wins, else a trap stores its vector.
    always_ff @(posedge clk) begin
        if (!rst_n)            tbr_q <= '0;
        else if (tbase_wr)     tbr_q <= tbase_wdata;
        else if (take_trap)    tbr_q <= vec;
    end

    // Output registers: vector on entry, restored context on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc    <= '0;
            new_npc   <= '0;
            st_ccr    <= '0;
            st_asi    <= '0;
            st_pstate <= '0;
            st_win    <= '0;
        end else if (take_trap) begin
            new_pc    <= vec;
            new_npc   <= vec + ADDR_W'(4);
            st_pstate <= go_red ? (PST_ENTRY | PST_RED_MASK) : PST_ENTRY;
            st_ccr    <= cur_ccr;
            st_asi    <= cur_asi;
            st_win    <= cur_win;
        end else if (take_ret) begin
            new_pc    <= ret_mode ? rd_pc  : rd_npc;
            new_npc   <= ret_mode ? rd_npc : rd_npc + ADDR_W'(4);
            st_ccr    <= rd_word[39:32];
            st_asi    <= rd_word[31:24];
            st_pstate <= rd_word[19:8];
            st_win    <= rd_word[7:0];
        end
    end

    // Expose the innermost saved slot and the level state.
    always_comb begin
        top_state = (lvl == '0) ? '0 : rd_word;
        top_tt    = (lvl == '0) ? '0 : rd_tt;
        trap_lvl  = lvl;
        err_state = err;
    end

    p_npc_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (new_npc == new_pc + ADDR_W'(4)));
    p_pstate_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (st_pstate[0] && st_pstate[2] && st_pstate[4]));
    p_ret_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && lvl == '0) |=> ($stable(new_pc) && $stable(new_npc)));
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !tbase_wr) |=> ($stable(new_pc) && $stable(st_pstate)));
endmodule

// File: tb/trap_level_stack_tb.sv
// Directed bench for the trap level state stack.
module trap_level_stack_tb_top;
    localparam int CLK_P = 10;
    localparam int MAXL  = 5;
    localparam int AW    = 32;
    localparam int LWB   = $clog2(MAXL + 1);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          tbase_wr = 0;
    logic [AW-1:0] tbase_wdata = '0;
    logic          trap_req = 0;
    logic [8:0]    trap_type = '0;
    logic [AW-1:0] cur_pc = '0, cur_npc = '0;
    logic [7:0]    cur_ccr = '0, cur_asi = '0, cur_win = '0;
    logic [11:0]   cur_pstate = '0;
    logic          ret_req = 0, ret_mode = 0;
    logic [AW-1:0] new_pc, new_npc;
    logic [7:0]    st_ccr, st_asi, st_win;
    logic [11:0]   st_pstate;
    logic [39:0]   top_state;
    logic [8:0]    top_tt;
    logic [LWB-1:0] trap_lvl;
    logic          err_state;

    int checks = 0;
    int errors = 0;

    // Bench model
    int            m_lvl = 0;
    logic [AW-1:0] m_tbr = '0;
    logic [AW-1:0] m_pc [MAXL];
    logic [AW-1:0] m_npc[MAXL];
    logic [39:0]   m_sw [MAXL];

    always #(CLK_P/2) clk = ~clk;

    trap_level_stack #(.MAX_LVL(MAXL), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tbase_wr(tbase_wr), .tbase_wdata(tbase_wdata),
        .trap_req(trap_req), .trap_type(trap_type), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_win(cur_win),
        .ret_req(ret_req), .ret_mode(ret_mode), .new_pc(new_pc), .new_npc(new_npc),
        .st_ccr(st_ccr), .st_asi(st_asi), .st_pstate(st_pstate), .st_win(st_win),
        .top_state(top_state), .top_tt(top_tt), .trap_lvl(trap_lvl), .err_state(err_state)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic load_tbr(input logic [AW-1:0] v);
        @(negedge clk);
        tbase_wr = 1; tbase_wdata = v;
        @(posedge clk); #1;
        tbase_wr = 0;
        m_tbr = v;
    endtask

    // Trap entry (optionally with a simultaneous return), checked against the model.
    task automatic do_trap(input string req, input logic [8:0] tt, input logic [AW-1:0] pc,
                           input logic [7:0] ccr, input logic [7:0] asi,
                           input logic [11:0] pst, input logic [7:0] win, input bit with_ret);
        logic [AW-1:0] vec;
        logic [11:0]   epst;
        logic [39:0]   sw;
        vec = (m_tbr & ~32'h7fff) | ((m_lvl > 1) ? 32'h4000 : 32'h0) | (AW'(tt) << 5);
        epst = (m_lvl == MAXL - 1) ? 12'h035 : 12'h015;
        sw = {ccr, asi, 4'h0, pst, win};
        @(negedge clk);
        trap_req = 1; trap_type = tt; cur_pc = pc; cur_npc = pc + 4;
        cur_ccr = ccr; cur_asi = asi; cur_pstate = pst; cur_win = win;
        ret_req = with_ret; ret_mode = 1;
        @(posedge clk); #1;
        trap_req = 0; ret_req = 0;
        m_pc[m_lvl] = pc; m_npc[m_lvl] = pc + 4; m_sw[m_lvl] = sw;
        m_lvl++; m_tbr = vec;
        chk({req, " R5 new_pc vector"}, new_pc, vec);
        chk({req, " R5 new_npc"}, new_npc, vec + 4);
        chk({req, " R4/R6 pstate"}, st_pstate, epst);
        chk({req, " R4 ccr/asi/win"}, {st_ccr, st_asi, st_win}, {ccr, asi, win});
        chk({req, " R6 level"}, trap_lvl, m_lvl);
        chk({req, " R3 saved word"}, top_state, sw);
        chk({req, " R2 saved type"}, top_tt, tt);
    endtask

    task automatic do_ret(input string req, input bit mode);
        int k;
        k = m_lvl - 1;
        @(negedge clk);
        ret_req = 1; ret_mode = mode;
        @(posedge clk); #1;
        ret_req = 0;
        m_lvl--;
        chk({req, " pc"}, new_pc, mode ? m_pc[k] : m_npc[k]);
        chk({req, " npc"}, new_npc, mode ? m_npc[k] : m_npc[k] + 4);
        chk({req, " fields"}, {st_ccr, st_asi, st_pstate, st_win},
            {m_sw[k][39:32], m_sw[k][31:24], m_sw[k][19:8], m_sw[k][7:0]});
        chk({req, " level"}, trap_lvl, m_lvl);
    endtask

    task automatic ret_at_zero();
        logic [AW-1:0] p, n;
        p = new_pc; n = new_npc;
        @(negedge clk);
        ret_req = 1; ret_mode = 0;
        @(posedge clk); #1;
        ret_req = 0;
        chk("R10 level stays 0", trap_lvl, 0);
        chk("R10 pc unchanged", new_pc, p);
        chk("R10 npc unchanged", new_npc, n);
    endtask

    task automatic trap_at_max();
        logic [AW-1:0] p;
        logic [11:0]   ps;
        p = new_pc; ps = st_pstate;
        @(negedge clk);
        trap_req = 1; trap_type = 9'h0AA;
        @(posedge clk); #1;
        trap_req = 0;
        chk("R7 err set", err_state, 1);
        chk("R7 level held", trap_lvl, MAXL);
        chk("R7 pc held", new_pc, p);
        chk("R7 pstate held", st_pstate, ps);
        @(negedge clk);
        ret_req = 1; ret_mode = 1;
        @(posedge clk); #1;
        ret_req = 0;
        chk("R7 return ignored in error", trap_lvl, MAXL);
        chk("R7 err sticky", err_state, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 level", trap_lvl, 0);
        chk("R1 err", err_state, 0);
        chk("R1 pc/npc", {new_pc, new_npc}, 64'h0);
        chk("R1 pstate", st_pstate, 0);
        @(negedge clk); rst_n = 1;
        chk("R1 top_state", top_state, 0);

        load_tbr(32'h1234_5FFF);
        do_trap("R12 first vector", 9'h041, 32'h0000_1000, 8'h3C, 8'h80, 12'h8A3, 8'h02, 0);
        do_trap("R11 trap with return", 9'h1FF, 32'h0000_2000, 8'h11, 8'h14, 12'h0F0, 8'h05, 1);
        do_ret("R8 resume-after", 0);
        do_ret("R9 re-execute", 1);
        ret_at_zero();

        do_trap("R6 lvl0", 9'h010, 32'h0000_3000, 8'hA1, 8'h04, 12'h111, 8'h01, 0);
        do_trap("R6 lvl1", 9'h020, 32'h0000_4000, 8'hA2, 8'h0C, 12'h222, 8'h02, 0);
        do_trap("R5 lvl2 nest bit", 9'h030, 32'h0000_5000, 8'hA3, 8'h10, 12'h333, 8'h03, 0);
        do_trap("R6 lvl3", 9'h040, 32'h0000_6000, 8'hA4, 8'h11, 12'h444, 8'h04, 0);
        do_trap("R6 red at lvl4", 9'h050, 32'h0000_7000, 8'hA5, 8'h18, 12'h555, 8'h05, 0);
        do_ret("R9 re-execute from max", 1);
        do_ret("R8 resume-after lvl4", 0);
        do_trap("R6 re-enter lvl3", 9'h060, 32'h0000_8000, 8'hB6, 8'h19, 12'hFFF, 8'h07, 0);
        do_trap("R6 red again", 9'h070, 32'h0000_9000, 8'hB7, 8'h1C, 12'h0AB, 8'h06, 0);
        trap_at_max();

        summary();
        $finish;
    end
endmodule